// File: doc/BRIEF.md
# Binary to Three-Digit Seven-Segment Driver

This block takes an unsigned 8-bit binary number and shows it as three decimal digits on three seven-segment displays. The number enters through a valid/ready port and is captured in a register. Its hundreds, tens and units digits are then worked out without a clock and decoded into segment patterns.

Each segment has two outputs: a level and an output enable. A pad buffer outside the block combines them into a three-state pin. When a segment is blanked, its enable is deasserted, so the pin floats. It is not driven to an inactive level.

Three plain control pins act directly on the outputs without waiting for a clock edge:
- The global blank pin turns every segment off. Because it acts at once, toggling it fast can dim the display.
- The leading-zero enable pin suppresses zero digits at the front of the number.
- The polarity pin inverts every segment level, so the same outputs suit common-anode, common-cathode or LCD segment drive.

The input port never applies back-pressure: `in_ready` is always 1, and every cycle with `in_valid` high loads a new value.

Top module: `sevseg_dec3`

## Requirements
- R1: `in_ready` is always 1. On a rising clock edge with `in_valid` high, `in_value` is captured. With `in_valid` low, the held value and the displayed digits stay unchanged.
- R2: After reset, the held value is 0.
- R3: The displayed digits are the decimal split of the held value, for every value from 0 to 255. Units occupy seg bits [6:0], tens [13:7] and hundreds [20:14]. Internally the three digits are packed into 10 bits: hundreds in [9:8], tens in [7:4], units in [3:0].
- R4: Within a digit, segment bits are ordered {g,f,e,d,c,b,a}, with bit 0 = a. With polarity 0, a lit segment has level 1. The lit sets for digits 0 to 9 are, in hex: 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R5: With leading-zero enable at 1, a hundreds digit of 0 is blanked.
- R6: With leading-zero enable at 1, a tens digit of 0 is blanked when the hundreds digit is also 0.
- R7: The units digit is never blanked by the leading-zero logic, so a held value of 0 shows "0".
- R8: With leading-zero enable at 0, all three digits are shown; for example, 7 shows "007".
- R9: With `blank` at 1, every output enable is 0. This takes effect without a clock edge.
- R10: With polarity at 1, every segment level is inverted.
- R11: A blanked digit has all 7 enables at 0 and its levels at the unlit value. A shown digit has all 7 enables at 1.
- R12: The internal decimal digits never exceed 9, the hundreds digit never exceeds 2, and the conversion never carries past the 10-bit packed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New binary value offered |
| in_ready | output | 1 | Always 1; the block never stalls |
| in_value | input | 8 | Binary value, 0 to 255 |
| blank | input | 1 | Turns all segments off at once |
| lz_en | input | 1 | Enables leading-zero suppression |
| invert | input | 1 | Inverts all segment levels |
| seg_lvl | output | 21 | Segment levels; units [6:0], tens [13:7], hundreds [20:14] |
| seg_oe | output | 21 | Segment output enables, laid out like seg_lvl |

## Verification
The embedded assertions check four things on every cycle:
- The held value stays stable whenever no transfer occurs.
- The units digit stays enabled whenever `blank` is low.
- `blank` removes every enable.
- A blanked digit carries the unlit level, and the decimal digits stay in range.

The bench's scenarios cover what the assertions cannot: the exact segment patterns of all 256 values under every combination of blank, leading-zero enable and polarity. They also show that `blank` acts between clock edges, and that reset clears the held value.

// File: rtl/sevseg_pkg.sv
package sevseg_pkg;
  typedef logic [6:0] seg_t;

  // {g,f,e,d,c,b,a}, bit 0 = a, 1 = lit
  function automatic seg_t glyph(input logic [3:0] d);
    case (d)
      4'd0: glyph = 7'h3F;
      4'd1: glyph = 7'h06;
      4'd2: glyph = 7'h5B;
      4'd3: glyph = 7'h4F;
      4'd4: glyph = 7'h66;
      4'd5: glyph = 7'h6D;
      4'd6: glyph = 7'h7D;
      4'd7: glyph = 7'h07;
      4'd8: glyph = 7'h7F;
      4'd9: glyph = 7'h6F;
      default: glyph = 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/sevseg_bin2bcd.sv
module sevseg_bin2bcd #(
  parameter int BIN_W = 8,
  parameter int N_DIG = 3,
  parameter int TOP_W = 2
) (
  input  logic [BIN_W-1:0]               bin,
  output logic [4*(N_DIG-1)+TOP_W-1:0]   bcd
);
  localparam int FULL_W = 4 * N_DIG;
  localparam int PK_W   = 4 * (N_DIG - 1) + TOP_W;

  logic [FULL_W-1:0] full;

  // shift-and-add-3, fully combinational
  always_comb begin
    full = '0;
    for (int i = BIN_W - 1; i >= 0; i--) begin
      for (int d = 0; d < N_DIG; d++) begin
        if (full[4*d +: 4] >= 4'd5) full[4*d +: 4] = full[4*d +: 4] + 4'd3;
      end
      full = {full[FULL_W-2:0], bin[i]};
    end
  end

  assign bcd = full[PK_W-1:0];

  always_comb begin
    assert_no_carry_out_R12: assert (full[FULL_W-1:PK_W] == '0)
      else $error("conversion exceeded packed width");
    for (int d = 0; d < N_DIG; d++) begin
      assert_digit_range_R12: assert (full[4*d +: 4] <= 4'd9)
        else $error("decimal digit out of range");
    end
  end
endmodule

// File: rtl/sevseg_lzb.sv
module sevseg_lzb #(
  parameter int N_DIG = 3
) (
  input  logic [N_DIG-1:0] dig_zero,
  input  logic             lz_en,
  output logic [N_DIG-1:0] dig_off
);
  logic [N_DIG-1:0] zrun;

  assign zrun[N_DIG-1] = dig_zero[N_DIG-1];
  generate
    for (genvar i = N_DIG - 2; i >= 0; i--) begin : g_run
      assign zrun[i] = zrun[i+1] & dig_zero[i];
    end
    for (genvar i = 1; i < N_DIG; i++) begin : g_off
      assign dig_off[i] = lz_en & zrun[i];
    end
  endgenerate
  assign dig_off[0] = 1'b0;
endmodule

// File: rtl/sevseg_digit.sv
module sevseg_digit
  import sevseg_pkg::*;
(
  input  logic [3:0] digit,
  input  logic       off,
  input  logic       blank,
  input  logic       invert,
  output seg_t       lvl,
  output seg_t       oe
);
  logic hide;
  assign hide = off | blank;
  assign lvl  = (hide ? 7'h00 : glyph(digit)) ^ {7{invert}};
  assign oe   = hide ? 7'h00 : 7'h7F;

  always_comb begin
    if (oe == 7'h00) begin
      assert_unlit_level_R11: assert (lvl == {7{invert}})
        else $error("hidden digit not at unlit level");
    end
  end
endmodule

// File: rtl/sevseg_dec3.sv
module sevseg_dec3
  import sevseg_pkg::*;
#(
  parameter int BIN_W = 8,
  parameter int N_DIG = 3,
  parameter int TOP_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BIN_W-1:0]   in_value,
  input  logic               blank,
  input  logic               lz_en,
  input  logic               invert,
  output logic [7*N_DIG-1:0] seg_lvl,
  output logic [7*N_DIG-1:0] seg_oe
);
  localparam int PK_W = 4 * (N_DIG - 1) + TOP_W;

  logic [BIN_W-1:0] value_q;
  logic [PK_W-1:0]  bcd;
  logic [N_DIG-1:0] dig_zero;
  logic [N_DIG-1:0] dig_off;
  logic [3:0]       dig [N_DIG];

  assign in_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)                    value_q <= '0;
    else if (in_valid && in_ready) value_q <= in_value;
  end

  sevseg_bin2bcd #(.BIN_W(BIN_W), .N_DIG(N_DIG), .TOP_W(TOP_W)) u_conv (
    .bin(value_q), .bcd(bcd)
  );

  generate
    for (genvar i = 0; i < N_DIG - 1; i++) begin : g_low
      assign dig[i] = bcd[4*i +: 4];
    end
  endgenerate
  assign dig[N_DIG-1] = 4'(bcd[PK_W-1 -: TOP_W]);

  generate
    for (genvar i = 0; i < N_DIG; i++) begin : g_dig
      assign dig_zero[i] = (dig[i] == 4'd0);
      sevseg_digit u_seg (
        .digit(dig[i]), .off(dig_off[i]), .blank(blank), .invert(invert),
        .lvl(seg_lvl[7*i +: 7]), .oe(seg_oe[7*i +: 7])
      );
    end
  endgenerate

  sevseg_lzb #(.N_DIG(N_DIG)) u_lzb (
    .dig_zero(dig_zero), .lz_en(lz_en), .dig_off(dig_off)
  );

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(value_q))
    else $error("held value changed without transfer");

  assert_units_shown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |-> seg_oe[6:0] == 7'h7F)
    else $error("units digit blanked");

  assert_blank_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> seg_oe == '0)
    else $error("segment enabled while blank");

  assert_top_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dig[N_DIG-1] <= 4'd2)
    else $error("hundreds digit out of range");
endmodule

// File: tb/sevseg_dec3_tb.sv
module sevseg_dec3_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_value = '0;
  logic        blank = 1'b0, lz_en = 1'b0, invert = 1'b0;
  logic [20:0] seg_lvl, seg_oe;

  typedef struct {
    logic [20:0] lvl;
    logic [20:0] oe;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sevseg_dec3 u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .blank(blank), .lz_en(lz_en), .invert(invert),
    .seg_lvl(seg_lvl), .seg_oe(seg_oe)
  );

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: pat = 7'h3F; 1: pat = 7'h06; 2: pat = 7'h5B; 3: pat = 7'h4F;
      4: pat = 7'h66; 5: pat = 7'h6D; 6: pat = 7'h7D; 7: pat = 7'h07;
      8: pat = 7'h7F; default: pat = 7'h6F;
    endcase
  endfunction

  function automatic exp_t model(input int v, input bit b, input bit lz,
                                 input bit inv, input string tag);
    exp_t e;
    int d[3];
    bit off[3];
    d[0] = v % 10; d[1] = (v / 10) % 10; d[2] = v / 100;
    off[2] = b || (lz && d[2] == 0);
    off[1] = b || (lz && d[2] == 0 && d[1] == 0);
    off[0] = b;
    for (int i = 0; i < 3; i++) begin
      e.lvl[7*i +: 7] = (off[i] ? 7'h00 : pat(d[i])) ^ {7{inv}};
      e.oe[7*i +: 7]  = off[i] ? 7'h00 : 7'h7F;
    end
    e.tag = tag;
    return e;
  endfunction

  task automatic check(input exp_t e);
    n_chk++;
    if (seg_lvl !== e.lvl || seg_oe !== e.oe) begin
      n_fail++;
      $display("FAIL %s: lvl=%h oe=%h expected lvl=%h oe=%h",
               e.tag, seg_lvl, seg_oe, e.lvl, e.oe);
    end
  endtask

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) check(q.pop_front());
  end

  task automatic drive(input int v, input bit b, input bit lz, input bit inv,
                       input bit vld, input int held, input string tag);
    @(negedge clk);
    in_value = 8'(v); in_valid = vld;
    blank = b; lz_en = lz; invert = inv;
    @(posedge clk);
    #1 in_valid = 1'b0;
    q.push_back(model(vld ? v : held, b, lz, inv, tag));
    while (q.size() > 0) @(posedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R2: reset value 0, shown with and without suppression (R7, R8)
    @(negedge clk);
    lz_en = 1'b0;
    #1 check(model(0, 0, 0, 0, "R2 reset shows 000"));
    lz_en = 1'b1;
    #1 check(model(0, 0, 1, 0, "R2/R7 reset shows single 0"));
    n_chk++;
    if (in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: in_ready=%b expected 1", in_ready);
    end

    // R3 R4 R5 R6 R8 R9 R10 R11 R12: full sweep
    for (int v = 0; v < 256; v++) begin
      for (int c = 0; c < 8; c++) begin
        drive(v, c[0], c[1], c[2], 1'b1, 0, "R3/R4/R5/R6/R8/R9/R10/R11/R12 sweep");
      end
    end

    // R5 R6 explicit corners
    drive(7, 0, 1, 0, 1, 0, "R6 tens suppressed for 7");
    drive(50, 0, 1, 0, 1, 0, "R5 hundreds off, inner zero kept for 50");
    drive(105, 0, 1, 0, 1, 0, "R6 inner zero kept for 105");
    drive(7, 0, 0, 0, 1, 0, "R8 shows 007");

    // R1: no transfer keeps held value 105
    drive(105, 0, 1, 1, 1, 0, "R10 load 105 inverted");
    drive(222, 0, 1, 1, 0, 105, "R1 hold without valid");
    drive(99, 0, 0, 0, 0, 105, "R1 hold without valid second");

    // R9: blank acts between clock edges
    @(negedge clk);
    blank = 1'b0; lz_en = 1'b0; invert = 1'b0;
    #1 check(model(105, 0, 0, 0, "R9 before blank"));
    #1 blank = 1'b1;
    #1 check(model(105, 1, 0, 0, "R9 blank mid-cycle"));
    #1 blank = 1'b0;
    #1 check(model(105, 0, 0, 0, "R9 unblank mid-cycle"));

    // R2: reset again clears a loaded value
    drive(200, 0, 1, 0, 1, 0, "R3 load 200");
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(model(0, 0, 1, 0, "R2 reset after 200"));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule